// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits at the start of an Ethernet receive path. It watches the first six bytes of each incoming frame, which form the 48-bit destination address. From them it returns one accept-or-drop verdict per frame. The bytes arrive one per accepted transfer, and a start strobe marks the first byte of a frame. While the bytes arrive, the block keeps a running reflected CRC-32 and assembles the address. When the sixth byte is taken, it combines three checks into a single registered verdict:
- an exact-match table of unicast addresses, one enable bit per entry;
- a 64-bit multicast hash table indexed from the CRC;
- four mode switches.

Software programs the table, the two 32-bit hash words and the mode word through a plain write port. Payload, frame check sequence and any data movement belong to other blocks.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `dec_vld` and `dec_accept` are 0, every exact-match entry is disabled, both hash words are zero and the mode word is zero. So with hash mode on, a non-broadcast multicast frame is dropped, and so is a unicast frame.
- R2: A frame begins with a transfer that has `rx_vld` and `rx_sof` high. The first byte is byte 0. Byte 0 is the first byte on the wire, and the address is `{b5,b4,b3,b2,b1,b0}`. `dec_vld` is high for exactly one cycle, the cycle after the clock edge that samples byte 5. Idle cycles between bytes are allowed. Bytes after byte 5, and bytes that arrive without an open frame, produce no verdict. A new start strobe discards a partly received frame. `dec_accept` is 0 whenever `dec_vld` is 0.
- R3: A destination with `b0[0]==0` is unicast. A unicast frame is accepted when its address equals an enabled exact-match entry. Entry i is written at `cfg_addr = 2*i`, with data `{b3,b2,b1,b0}`. It is also written at `cfg_addr = 2*i+1`, with `b5` in bits 15:8, `b4` in bits 7:0 and the enable in bit 31. `NUM_ENT` is 16 or 32.
- R4: An entry whose enable bit is 0 never matches, even when its stored address equals the destination.
- R5: The hash index is formed in four steps. A reflected CRC-32 with polynomial 0xEDB88320 and seed 0xFFFFFFFF runs over b0..b5, each byte taken LSB first. The result is complemented, then bit-reversed, and bits 31:26 of that value form the 6-bit index. Index bit 5 picks the high hash word (1) or the low hash word (0), and index bits 4:0 pick the bit within that word. The low word is at `cfg_addr = 2*NUM_ENT` and the high word at `2*NUM_ENT+1`.
- R6: The mode word is at `cfg_addr = 2*NUM_ENT+2`, and bit 2 is hash-multicast. With that bit set, a multicast frame (`b0[0]==1`) is accepted when its indexed hash bit is 1. Otherwise the hash gives no acceptance.
- R7: Mode bit 1 is pass-all-multicast. With it set, every multicast frame is accepted whatever the hash words hold. A unicast frame is still judged by the exact-match table.
- R8: Mode bit 0 is promiscuous. With it set, every frame is accepted.
- R9: Mode bit 3 is receive-all. With it set, every frame is accepted, including frames the address checks would drop.
- R10: The all-ones address is accepted in every mode.
- R11: A multicast frame that is not broadcast is dropped when mode bits 0 to 3 are all 0, whatever the hash words hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_vld | input | 1 | A receive byte is present this cycle |
| rx_sof | input | 1 | Marks the present byte as byte 0 of a frame |
| rx_byte | input | 8 | Receive byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(2*NUM_ENT)+1 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| dec_vld | output | 1 | Verdict strobe, one cycle per frame |
| dec_accept | output | 1 | Verdict: 1 accept, 0 drop |

## Verification
The verdict is due exactly one clock after the edge that samples byte 5, whatever idle gaps came earlier in the frame. When the driver sends byte 5, it queues the expected verdict together with that cycle number plus one. The monitor samples on the falling edge. It compares both the value and the cycle of each `dec_vld` pulse, and it reports any pulse that has no queued entry. This is how extra bytes, orphan bytes and restarted frames are shown to produce no verdict.

Configuration writes take effect on the edge that samples them. Each frame is therefore sent only after its writes have completed, and the expected verdict comes from a bench-side copy of the written values.

// File: rtl/rxf_pkg.sv
// Shared types and the byte-wide CRC step for the receive address filter.
// Assumes bytes are fed LSB first into a reflected CRC-32.
package rxf_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

    // Mode word layout, bit 3 down to bit 0.
    typedef struct packed {
        logic rx_all;
        logic hash_mc;
        logic pass_mc;
        logic promisc;
    } rxf_mode_t;

    // Advance a reflected CRC-32 by one byte, LSB first.
    function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] d);
        logic [31:0] c;
        c = c_in ^ {24'd0, d};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/rxf_collect.sv
// Assembles the six destination bytes and the running CRC.
// Assumes: a byte with sof opens a frame; bytes beyond the sixth or outside
// a frame are ignored. Outputs addr_full/crc_full are valid while last_take=1.
module rxf_collect
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_vld,
    input  logic        rx_sof,
    input  logic [7:0]  rx_byte,
    output logic        last_take,
    output logic [47:0] addr_full,
    output logic [31:0] crc_full
);

    localparam int NBYTES = 6;

    logic [47:0] addr_q;
    logic [31:0] crc_q;
    logic [2:0]  cnt_q;
    logic        open_q;
    logic [2:0]  idx;
    logic        take;
    logic [31:0] crc_base;

    // Pick the byte slot and decide whether this byte belongs to a frame.
    always_comb begin
        idx       = rx_sof ? 3'd0 : cnt_q;
        take      = rx_vld && (rx_sof || open_q);
        last_take = take && (idx == 3'(NBYTES - 1));
        crc_base  = rx_sof ? CRC_SEED : crc_q;
    end

    // Store bytes, advance the CRC and track the byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            crc_q  <= CRC_SEED;
            cnt_q  <= '0;
            open_q <= 1'b0;
        end else if (take) begin
            addr_q[idx*8 +: 8] <= rx_byte;
            crc_q              <= crc_step(crc_base, rx_byte);
            cnt_q              <= idx + 3'd1;
            open_q             <= !last_take;
        end
    end

    // Full address and CRC including the byte arriving this cycle.
    always_comb begin
        addr_full         = addr_q;
        addr_full[47:40]  = rx_byte;
        crc_full          = crc_step(crc_q, rx_byte);
    end

endmodule

// File: rtl/rxf_exact.sv
// Table of exact-match unicast entries, each with its own enable bit.
// Assumes: entry i low word at address 2*i, high half and enable at 2*i+1.
module rxf_exact #(
    parameter int NUM_ENT = 16,
    parameter int AW      = $clog2(2 * NUM_ENT) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [31:0]   cfg_wdata,
    input  logic [47:0]   addr,
    output logic          hit
);

    logic [NUM_ENT-1:0] hit_vec;
    logic               unused_bits;

    assign unused_bits = ^cfg_wdata[30:16];

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        localparam logic [AW-1:0] LO_ADR = AW'(2 * i);
        localparam logic [AW-1:0] HI_ADR = AW'(2 * i + 1);
        logic [47:0] val_q;
        logic        en_q;

        // Load this entry from the configuration port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
                en_q  <= 1'b0;
            end else if (cfg_we && cfg_addr == LO_ADR) begin
                val_q[31:0] <= cfg_wdata;
            end else if (cfg_we && cfg_addr == HI_ADR) begin
                val_q[47:32] <= cfg_wdata[15:0];
                en_q         <= cfg_wdata[31];
            end
        end

        // Compare the destination against this entry.
        assign hit_vec[i] = en_q && (val_q == addr);
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/rxf_hash.sv
// 64-bit multicast hash table split across a low and a high word.
// Assumes crc is the final reflected CRC of the six address bytes.
module rxf_hash #(
    parameter int AW   = 6,
    parameter int BASE = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [31:0]   cfg_wdata,
    input  logic [31:0]   crc,
    output logic          bit_set
);

    localparam logic [AW-1:0] LO_ADR = AW'(BASE);
    localparam logic [AW-1:0] HI_ADR = AW'(BASE + 1);

    logic [31:0] lo_q;
    logic [31:0] hi_q;
    logic [5:0]  hidx;
    logic        unused_bits;

    assign unused_bits = ^crc[31:6];

    // Load the hash words from the configuration port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (cfg_we && cfg_addr == LO_ADR) begin
            lo_q <= cfg_wdata;
        end else if (cfg_we && cfg_addr == HI_ADR) begin
            hi_q <= cfg_wdata;
        end
    end

    // Index = top six bits of the bit-reversed complemented CRC.
    always_comb begin
        for (int k = 0; k < 6; k++) begin
            hidx[5-k] = ~crc[k];
        end
        bit_set = hidx[5] ? hi_q[hidx[4:0]] : lo_q[hidx[4:0]];
    end

endmodule

// File: rtl/rx_addr_filter.sv
// Receive destination address filter: exact match, multicast hash and modes.
// Assumes one byte per rx_vld, frame opened by rx_sof; one verdict per frame
// the cycle after byte 5. Configuration writes act on the sampling edge.
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int NUM_ENT = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_vld,
    input  logic                        rx_sof,
    input  logic [7:0]                  rx_byte,
    input  logic                        cfg_we,
    input  logic [$clog2(2*NUM_ENT):0]  cfg_addr,
    input  logic [31:0]                 cfg_wdata,
    output logic                        dec_vld,
    output logic                        dec_accept
);

    localparam int AW       = $clog2(2 * NUM_ENT) + 1;
    localparam int CTL_BASE = 2 * NUM_ENT;
    localparam logic [AW-1:0] MODE_ADR = AW'(CTL_BASE + 2);

    logic        last_take;
    logic [47:0] addr_full;
    logic [31:0] crc_full;
    logic        exact_hit;
    logic        hash_bit;
    logic        is_mc;
    logic        is_bc;
    logic        accept;
    rxf_mode_t   mode_q;
    logic        unused_bits;

    assign unused_bits = ^cfg_wdata[31:4];

    rxf_collect u_col (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_vld    (rx_vld),
        .rx_sof    (rx_sof),
        .rx_byte   (rx_byte),
        .last_take (last_take),
        .addr_full (addr_full),
        .crc_full  (crc_full)
    );

    rxf_exact #(.NUM_ENT(NUM_ENT), .AW(AW)) u_exact (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .addr      (addr_full),
        .hit       (exact_hit)
    );

    rxf_hash #(.AW(AW), .BASE(CTL_BASE)) u_hash (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .crc       (crc_full),
        .bit_set   (hash_bit)
    );

    // Mode word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (cfg_we && cfg_addr == MODE_ADR) begin
            mode_q <= rxf_mode_t'(cfg_wdata[3:0]);
        end
    end

    // Combine address class, table results and modes into a verdict.
    always_comb begin
        is_mc  = addr_full[0];
        is_bc  = &addr_full;
        accept = mode_q.rx_all || mode_q.promisc || is_bc ||
                 (is_mc ? (mode_q.pass_mc || (mode_q.hash_mc && hash_bit))
                        : exact_hit);
    end

    // Register the verdict one cycle after byte 5.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld    <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_vld    <= last_take;
            dec_accept <= last_take && accept;
        end
    end

endmodule

// File: rtl/rx_addr_filter_chk.sv
// Property checker for rx_addr_filter, attached by bind.
module rx_addr_filter_chk
    import rxf_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      last_take,
    input logic      is_mc,
    input logic      is_bc,
    input rxf_mode_t mode_q,
    input logic      dec_vld,
    input logic      dec_accept
);

    AST_RST_QUIET:     assert property (@(posedge clk) !rst_n |=> !dec_vld && !dec_accept); // R1
    AST_ONE_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) dec_vld |=> !dec_vld); // R2
    AST_VLD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) last_take |=> dec_vld); // R2
    AST_ACC_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n) dec_accept |-> dec_vld); // R2
    AST_PASS_MC:       assert property (@(posedge clk) disable iff (!rst_n)
                                        last_take && is_mc && mode_q.pass_mc |=> dec_accept); // R7
    AST_PROMISC:       assert property (@(posedge clk) disable iff (!rst_n)
                                        last_take && mode_q.promisc |=> dec_accept); // R8
    AST_RX_ALL:        assert property (@(posedge clk) disable iff (!rst_n)
                                        last_take && mode_q.rx_all |=> dec_accept); // R9
    AST_BCAST:         assert property (@(posedge clk) disable iff (!rst_n)
                                        last_take && is_bc |=> dec_accept); // R10

endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .last_take  (last_take),
    .is_mc      (is_mc),
    .is_bc      (is_bc),
    .mode_q     (mode_q),
    .dec_vld    (dec_vld),
    .dec_accept (dec_accept)
);

// File: tb/rx_addr_filter_bench.sv
// Scoreboard bench: the driver queues expected verdicts with their due cycle,
// the monitor pops and compares on each dec_vld pulse.
module rx_addr_filter_bench;

    localparam int NUM_ENT = 16;
    localparam int AW      = $clog2(2 * NUM_ENT) + 1;
    localparam int HLO     = 2 * NUM_ENT;
    localparam int HHI     = 2 * NUM_ENT + 1;
    localparam int MODE    = 2 * NUM_ENT + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_vld = 1'b0;
    logic          rx_sof = 1'b0;
    logic [7:0]    rx_byte = '0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          dec_vld;
    logic          dec_accept;

    rx_addr_filter #(.NUM_ENT(NUM_ENT)) u_rx_addr_filter (
        .clk (clk), .rst_n (rst_n), .rx_vld (rx_vld), .rx_sof (rx_sof),
        .rx_byte (rx_byte), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
        .cfg_wdata (cfg_wdata), .dec_vld (dec_vld), .dec_accept (dec_accept)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    q_acc[$];
    int    q_cyc[$];
    string q_tag[$];

    // Bench-side copy of the configuration.
    logic [47:0] sh_val [NUM_ENT];
    bit          sh_en  [NUM_ENT];
    logic [31:0] sh_lo = '0, sh_hi = '0;
    logic [3:0]  sh_mode = '0;

    function automatic logic [5:0] hidx_of(input logic [47:0] a);
        logic [31:0] c, r;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            bit fb;
            fb = c[0] ^ a[i];
            c  = c >> 1;
            if (fb) c = c ^ 32'hEDB8_8320;
        end
        c = ~c;
        for (int i = 0; i < 32; i++) r[31-i] = c[i];
        return r[31:26];
    endfunction

    function automatic bit model(input logic [47:0] a);
        logic [5:0] h;
        bit hb, hit;
        h   = hidx_of(a);
        hb  = h[5] ? sh_hi[h[4:0]] : sh_lo[h[4:0]];
        hit = 0;
        for (int i = 0; i < NUM_ENT; i++) if (sh_en[i] && sh_val[i] == a) hit = 1;
        if (sh_mode[3] || sh_mode[0] || &a) return 1;
        if (a[0]) return sh_mode[1] || (sh_mode[2] && hb);
        return hit;
    endfunction

    task automatic wr(input int adr, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(adr); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (adr < 2 * NUM_ENT) begin
            if (adr % 2 == 0) sh_val[adr/2][31:0] = d;
            else begin sh_val[adr/2][47:32] = d[15:0]; sh_en[adr/2] = d[31]; end
        end else if (adr == HLO) sh_lo = d;
        else if (adr == HHI) sh_hi = d;
        else if (adr == MODE) sh_mode = d[3:0];
    endtask

    task automatic set_ent(input int i, input logic [47:0] a, input bit en);
        wr(2 * i, a[31:0]);
        wr(2 * i + 1, {en, 15'd0, a[47:32]});
    endtask

    // Send nb bytes of a (bytes past 5 repeat byte 0); gap idle cycles between.
    task automatic send(input logic [47:0] a, input int nb, input int gap, input string tag);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            rx_vld = 1'b1; rx_sof = (i == 0); rx_byte = (i < 6) ? a[8*i +: 8] : a[7:0];
            if (i == 5) begin
                q_acc.push_back(model(a)); q_cyc.push_back(cyc + 1); q_tag.push_back(tag);
            end
            if (gap > 0 && i < nb - 1) begin
                @(negedge clk); rx_vld = 1'b0; rx_sof = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk); rx_vld = 1'b0; rx_sof = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_acc(input logic [47:0] a, input bit want, input string tag);
        if (model(a) != want) begin
            n_bad++;
            $display("FAIL %s: bench model gives %0b expected %0b", tag, model(a), want);
        end
        send(a, 6, 0, tag);
    endtask

    // Monitor: compare each verdict with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && dec_vld) begin
            n_chk++;
            if (q_acc.size() == 0) begin
                n_bad++;
                $display("FAIL R2: unexpected verdict acc=%0b at cycle %0d, expected none", dec_accept, cyc);
            end else begin
                bit e; int ec; string t;
                e = q_acc.pop_front(); ec = q_cyc.pop_front(); t = q_tag.pop_front();
                if (dec_accept !== e || cyc != ec) begin
                    n_bad++;
                    $display("FAIL %s: acc=%0b cycle=%0d, expected acc=%0b cycle=%0d", t, dec_accept, cyc, e, ec);
                end
            end
        end
    end

    localparam logic [47:0] U1 = 48'h5544_3322_1100;
    localparam logic [47:0] U2 = 48'h0A0B_0C0D_0E02;
    localparam logic [47:0] U3 = 48'hFEDC_BA98_7654;
    localparam logic [47:0] U4 = 48'h1234_5678_9ABC;
    localparam logic [47:0] MA = 48'h0100_005E_0001;
    localparam logic [47:0] MB = 48'h3300_0000_0133;
    localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

    bit done = 0;

    initial begin
        logic [5:0] ia;
        for (int i = 0; i < NUM_ENT; i++) begin sh_val[i] = '0; sh_en[i] = 0; end
        repeat (4) @(negedge clk);
        n_chk++;
        if (dec_vld !== 1'b0 || dec_accept !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: in reset vld=%0b acc=%0b, expected 0 0", dec_vld, dec_accept);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (dec_vld !== 1'b0 || dec_accept !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: after reset vld=%0b acc=%0b, expected 0 0", dec_vld, dec_accept);
        end
        wr(MODE, 32'h4);
        expect_acc(MA, 0, "R1 multicast with empty hash");
        expect_acc(U1, 0, "R1 unicast with empty table");
        // Exact-match table.
        set_ent(0, U1, 1);
        set_ent(5, U2, 0);
        set_ent(NUM_ENT - 1, U3, 1);
        expect_acc(U1, 1, "R3 entry 0 match");
        expect_acc(U3, 1, "R3 last entry match");
        expect_acc(U4, 0, "R3 no match");
        expect_acc(U2, 0, "R4 disabled entry");
        set_ent(5, U2, 1);
        expect_acc(U2, 1, "R4 entry enabled");
        wr(1, {1'b0, 15'd0, U1[47:32]});
        expect_acc(U1, 0, "R4 entry disabled again");
        // Hash table.
        ia = hidx_of(MA);
        if (ia[5]) wr(HHI, 32'd1 << ia[4:0]); else wr(HLO, 32'd1 << ia[4:0]);
        expect_acc(MA, 1, "R5 indexed bit set");
        send(MB, 6, 0, "R6 other multicast");
        if (ia[5]) begin wr(HHI, ~(32'd1 << ia[4:0])); wr(HLO, 32'hFFFF_FFFF); end
        else begin wr(HLO, ~(32'd1 << ia[4:0])); wr(HHI, 32'hFFFF_FFFF); end
        expect_acc(MA, 0, "R5 only indexed bit clear");
        expect_acc(U4, 0, "R6 hash ignores unicast");
        wr(MODE, 32'h0);
        if (ia[5]) wr(HHI, 32'hFFFF_FFFF); else wr(HLO, 32'hFFFF_FFFF);
        expect_acc(MA, 0, "R11 hash off, all bits set");
        expect_acc(BC, 1, "R10 broadcast mode 0");
        expect_acc(U3, 1, "R3 unicast still matches in mode 0");
        wr(HLO, 32'h0); wr(HHI, 32'h0);
        wr(MODE, 32'h2);
        expect_acc(MB, 1, "R7 pass-all multicast");
        expect_acc(MA, 1, "R7 pass-all multicast empty hash");
        expect_acc(U4, 0, "R7 unicast not passed");
        wr(MODE, 32'h1);
        expect_acc(U4, 1, "R8 promiscuous unicast");
        expect_acc(MB, 1, "R8 promiscuous multicast");
        wr(MODE, 32'h8);
        expect_acc(U4, 1, "R9 receive-all unicast");
        expect_acc(MA, 1, "R9 receive-all multicast");
        wr(MODE, 32'h0);
        expect_acc(BC, 1, "R10 broadcast after modes");
        // Timing and framing.
        send(U3, 6, 3, "R2 gapped frame");
        send(U3, 9, 0, "R2 extra bytes");
        send(U4, 3, 0, "R2 partial (no verdict)");
        send(U3, 6, 1, "R2 restart after partial");
        @(negedge clk); rx_vld = 1'b1; rx_byte = 8'h00;
        repeat (8) @(negedge clk);
        rx_vld = 1'b0;
        repeat (4) @(negedge clk);
        n_chk++;
        if (q_acc.size() != 0) begin
            n_bad++;
            $display("FAIL R2: %0d verdicts missing, expected 0", q_acc.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule